// File: doc/BRIEF.md
# Weighted Two-Class Code-Block Arbiter

This block lets an uplink request stream and a downlink request stream share one downstream link, one code block at a time. Each class offers blocks through a valid/ready handshake. After a block is accepted, the link stays busy until the downstream side pulses `cb_done`. Only then can the next block be granted, so a grant never changes in the middle of a block.

Under contention each class gets a burst of consecutive blocks. The length of the burst is three blocks per unit of its 8-bit weight, and a weight of zero counts as one. The budget counts blocks, not cycles: a long block and a short block use the same share. When only one class requests, it is served without limit. When the class being served runs out of requests, the other class takes over at once and starts a fresh burst.

The controller has three states:
- FREE: the link is idle and a grant may be given.
- UL_BLK: an uplink block is in flight.
- DL_BLK: a downlink block is in flight.

Its transitions are:
- FREE→UL_BLK when an uplink handshake completes.
- FREE→DL_BLK when a downlink handshake completes.
- UL_BLK→FREE and DL_BLK→FREE on `cb_done`.

Top module: `cb_weighted_arb`

## Requirements
- R1: After reset the link is free (`busy`=0), the burst counter is zero and the current class is uplink, so the first contended grant goes to uplink.
- R2: At most one of `ul_ready`/`dl_ready` is high in any cycle, and neither is high while `busy`=1.
- R3: A handshake makes `busy`=1 on the next cycle. `busy` stays high, with `busy_class` unchanged, until a cycle with `cb_done`=1, after which `busy` is 0. A `cb_done` while `busy`=0 has no effect.
- R4: With both classes requesting, the current class is granted until it has taken 3*w blocks in its burst (w its weight), and then the other class is granted.
- R5: A weight of 0 gives a burst of 3 blocks, the same as a weight of 1.
- R6: When only one class has `valid` high and the link is free, that class is granted, however many blocks it has already taken.
- R7: When the current class stops requesting and the other class is granted, the new class starts a fresh burst of its full budget.
- R8: The number of cycles between accept and `cb_done` does not affect the burst budget.
- R9: If a solo class has run past its budget and the other class then starts requesting, the next grant goes to the other class.
- R10: `busy_class` is 0 for an uplink block and 1 for a downlink block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ul_weight | input | WEIGHT_W | Uplink weight, in units of 3 blocks |
| dl_weight | input | WEIGHT_W | Downlink weight, in units of 3 blocks |
| ul_valid | input | 1 | Uplink offers a code block |
| ul_ready | output | 1 | Uplink block accepted this cycle |
| dl_valid | input | 1 | Downlink offers a code block |
| dl_ready | output | 1 | Downlink block accepted this cycle |
| cb_done | input | 1 | The block on the link has finished |
| busy | output | 1 | A block is in flight |
| busy_class | output | 1 | Class of the block in flight (0 uplink, 1 downlink) |

## Verification
The bench builds the block with its default parameters: 8-bit weights and three blocks per weight unit. It drives small weights (0, 1, 2 and 4) so that several burst switches, the zero-weight floor and solo runs that go past the budget all fit in a short run. Block lengths vary from one to nine cycles, which shows that the budget counts blocks rather than cycles. A behavioural model of the burst rule is compared against the ports on every cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    typedef enum logic {
        CLS_UL = 1'b0,
        CLS_DL = 1'b1
    } cls_e;

    typedef enum logic [1:0] {
        S_FREE   = 2'd0,
        S_UL_BLK = 2'd1,
        S_DL_BLK = 2'd2
    } state_e;
endpackage

// File: rtl/wcb_budget.sv
// Converts a class weight into its burst length in code blocks.
module wcb_budget #(
    parameter int WEIGHT_W    = 8,
    parameter int UNIT_BLOCKS = 3,
    parameter int CNT_W       = 10
) (
    input  logic [WEIGHT_W-1:0] weight,
    output logic [CNT_W-1:0]    budget
);
    logic [WEIGHT_W-1:0] eff_weight;

    // a zero weight is floored to one unit so no class starves
    assign eff_weight = (weight == '0) ? WEIGHT_W'(1) : weight;
    assign budget     = CNT_W'(eff_weight) * CNT_W'(UNIT_BLOCKS);
endmodule

// File: rtl/wcb_burst_ctr.sv
// Tracks which class owns the current burst and how many blocks it has taken.
module wcb_burst_ctr
    import wcb_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  cls_e             take_cls,
    output cls_e             cur_cls,
    output logic [CNT_W-1:0] used
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cls <= CLS_UL;
            used    <= '0;
        end else if (take) begin
            if (take_cls == cur_cls) begin
                if (used != '1) begin
                    used <= used + CNT_W'(1);
                end
            end else begin
                cur_cls <= take_cls;
                used    <= CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wcb_select.sv
// Picks the class that would be granted next from the requests and burst state.
module wcb_select
    import wcb_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             ul_req,
    input  logic             dl_req,
    input  cls_e             cur_cls,
    input  logic [CNT_W-1:0] used,
    input  logic [CNT_W-1:0] ul_budget,
    input  logic [CNT_W-1:0] dl_budget,
    output logic             any_req,
    output cls_e             sel_cls
);
    logic [CNT_W-1:0] cur_budget;
    logic             exhausted;
    cls_e             other_cls;

    assign cur_budget = (cur_cls == CLS_UL) ? ul_budget : dl_budget;
    assign exhausted  = (used >= cur_budget);
    assign other_cls  = (cur_cls == CLS_UL) ? CLS_DL : CLS_UL;

    always_comb begin
        any_req = 1'b1;
        sel_cls = cur_cls;
        unique case ({ul_req, dl_req})
            2'b11: sel_cls = exhausted ? other_cls : cur_cls;
            2'b10: sel_cls = CLS_UL;
            2'b01: sel_cls = CLS_DL;
            default: begin
                any_req = 1'b0;
                sel_cls = cur_cls;
            end
        endcase
    end
endmodule

// File: rtl/cb_weighted_arb.sv
module cb_weighted_arb
    import wcb_pkg::*;
#(
    parameter int WEIGHT_W    = 8,
    parameter int UNIT_BLOCKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WEIGHT_W-1:0] ul_weight,
    input  logic [WEIGHT_W-1:0] dl_weight,
    input  logic                ul_valid,
    output logic                ul_ready,
    input  logic                dl_valid,
    output logic                dl_ready,
    input  logic                cb_done,
    output logic                busy,
    output logic                busy_class
);
    localparam int MAX_BUDGET = ((1 << WEIGHT_W) - 1) * UNIT_BLOCKS;
    localparam int CNT_W      = $clog2(MAX_BUDGET + 1);
    localparam int NUM_CLS    = 2;

    state_e state_q, state_d;
    logic [NUM_CLS-1:0][WEIGHT_W-1:0] weights;
    logic [NUM_CLS-1:0][CNT_W-1:0]    budgets;
    logic             any_req;
    cls_e             sel_cls;
    cls_e             cur_cls;
    logic [CNT_W-1:0] used;
    logic             take;

    assign weights[0] = ul_weight;
    assign weights[1] = dl_weight;

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_budget
        wcb_budget #(
            .WEIGHT_W   (WEIGHT_W),
            .UNIT_BLOCKS(UNIT_BLOCKS),
            .CNT_W      (CNT_W)
        ) u_budget (
            .weight(weights[g]),
            .budget(budgets[g])
        );
    end

    wcb_select #(.CNT_W(CNT_W)) u_select (
        .ul_req   (ul_valid),
        .dl_req   (dl_valid),
        .cur_cls  (cur_cls),
        .used     (used),
        .ul_budget(budgets[0]),
        .dl_budget(budgets[1]),
        .any_req  (any_req),
        .sel_cls  (sel_cls)
    );

    assign take = (ul_valid && ul_ready) || (dl_valid && dl_ready);

    wcb_burst_ctr #(.CNT_W(CNT_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .take_cls(sel_cls),
        .cur_cls (cur_cls),
        .used    (used)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FREE: begin
                if (take) begin
                    state_d = (sel_cls == CLS_DL) ? S_DL_BLK : S_UL_BLK;
                end
            end
            S_UL_BLK, S_DL_BLK: begin
                if (cb_done) begin
                    state_d = S_FREE;
                end
            end
            default: state_d = S_FREE;
        endcase
    end

    // outputs
    always_comb begin
        ul_ready   = 1'b0;
        dl_ready   = 1'b0;
        busy       = 1'b0;
        busy_class = 1'b0;
        unique case (state_q)
            S_FREE: begin
                ul_ready = any_req && (sel_cls == CLS_UL);
                dl_ready = any_req && (sel_cls == CLS_DL);
            end
            S_UL_BLK: begin
                busy       = 1'b1;
                busy_class = 1'b0;
            end
            S_DL_BLK: begin
                busy       = 1'b1;
                busy_class = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wcb_arb_checker.sv
module wcb_arb_checker (
    input logic clk,
    input logic rst_n,
    input logic ul_valid,
    input logic ul_ready,
    input logic dl_valid,
    input logic dl_ready,
    input logic cb_done,
    input logic busy,
    input logic busy_class
);
    a_r2_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(ul_ready && dl_ready));

    a_r2_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ul_ready && !dl_ready));

    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cb_done) |=> busy);

    a_r3_class_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cb_done) |=> $stable(busy_class));

    a_r3_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cb_done) |=> !busy);

    a_r10_accept_ul: assert property (@(posedge clk) disable iff (!rst_n)
        (ul_valid && ul_ready) |=> (busy && !busy_class));

    a_r10_accept_dl: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_valid && dl_ready) |=> (busy && busy_class));

    a_r6_sole_ul: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ul_valid && !dl_valid) |-> ul_ready);

    a_r6_sole_dl: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dl_valid && !ul_valid) |-> dl_ready);
endmodule

bind cb_weighted_arb wcb_arb_checker u_wcb_arb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ul_valid  (ul_valid),
    .ul_ready  (ul_ready),
    .dl_valid  (dl_valid),
    .dl_ready  (dl_ready),
    .cb_done   (cb_done),
    .busy      (busy),
    .busy_class(busy_class)
);

// File: tb/test_cb_weighted_arb.sv
module test_cb_weighted_arb;
    localparam int CLK_PERIOD = 10;
    localparam int SAT_USED   = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ul_weight = 8'd2;
    logic [7:0] dl_weight = 8'd1;
    logic       ul_valid = 1'b0;
    logic       dl_valid = 1'b0;
    logic       cb_done = 1'b0;
    logic       ul_ready, dl_ready, busy, busy_class;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int m_busy = 0;
    int m_cls = 0;
    int m_cur = 0;
    int m_used = 0;
    int hs = 0;
    int hs_cls = 0;

    cb_weighted_arb i_cb_weighted_arb (
        .clk(clk), .rst_n(rst_n),
        .ul_weight(ul_weight), .dl_weight(dl_weight),
        .ul_valid(ul_valid), .ul_ready(ul_ready),
        .dl_valid(dl_valid), .dl_ready(dl_ready),
        .cb_done(cb_done), .busy(busy), .busy_class(busy_class)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int budget_of(int cls);
        int w;
        w = (cls == 0) ? int'(ul_weight) : int'(dl_weight);
        if (w == 0) w = 1;
        return 3 * w;
    endfunction

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock cycle: drive inputs, compare ports with the model, advance the model
    task automatic step(input logic uv, input logic dv, input logic done, input string tag);
        int e_ul, e_dl, sel, act, exp;
        @(negedge clk);
        ul_valid = uv;
        dl_valid = dv;
        cb_done  = done;
        #1;
        e_ul = 0; e_dl = 0; sel = m_cur;
        hs = 0;
        if (m_busy == 0) begin
            if (uv && dv) sel = (m_used >= budget_of(m_cur)) ? 1 - m_cur : m_cur;
            else if (uv) sel = 0;
            else if (dv) sel = 1;
            if (uv || dv) begin
                if (sel == 0) e_ul = 1; else e_dl = 1;
            end
        end
        act = {ul_ready, dl_ready, busy, busy_class};
        exp = (e_ul << 3) | (e_dl << 2) | (m_busy << 1) | (m_busy ? m_cls : 0);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (R2/R3 ports {ul_rdy,dl_rdy,busy,cls}): actual %b expected %b",
                     tag, act[3:0], exp[3:0]);
        end
        if (e_ul || e_dl) begin
            hs = 1;
            hs_cls = sel;
            if (sel == m_cur) begin
                if (m_used < SAT_USED) m_used++;
            end else begin
                m_cur = sel;
                m_used = 1;
            end
            m_busy = 1;
            m_cls = sel;
        end else if (m_busy && done) begin
            m_busy = 0;
        end
    endtask

    // offer one block with the given requests, hold it len cycles, then finish it
    task automatic run_block(input logic uv, input logic dv, input int len,
                             input string tag, output int cls);
        int guard;
        guard = 0;
        hs = 0;
        while (hs == 0 && guard < 50) begin
            step(uv, dv, 1'b0, tag);
            guard++;
        end
        cls = hs_cls;
        for (int i = 1; i < len; i++) step(uv, dv, 1'b0, tag);
        step(uv, dv, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        int exp_seq[12];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(1'b0, 1'b0, 1'b0, "R1 reset idle");
        check_val("R1 busy after reset", int'(busy), 0);
        // R3: done while free ignored
        step(1'b0, 1'b0, 1'b1, "R3 stray done");
        step(1'b0, 1'b0, 1'b0, "R3 stray done after");
        check_val("R3 busy after stray done", int'(busy), 0);

        // R1, R4: ul weight 2 (6 blocks), dl weight 1 (3 blocks)
        for (int i = 0; i < 12; i++) exp_seq[i] = (i < 6) ? 0 : (i < 9) ? 1 : 0;
        for (int i = 0; i < 12; i++) begin
            run_block(1'b1, 1'b1, 2, "R4 contention", c);
            check_val(i == 0 ? "R1 first grant uplink" : "R4 burst order", c, exp_seq[i]);
        end

        // R5: zero weight acts as one unit; ul at weight 1 is already exhausted
        ul_weight = 8'd1;
        dl_weight = 8'd0;
        for (int i = 0; i < 6; i++) begin
            run_block(1'b1, 1'b1, 1, "R5 zero weight", c);
            check_val("R5 zero weight order", c, (i < 3) ? 1 : 0);
        end

        // R6: solo downlink beyond its budget of 3
        for (int i = 0; i < 10; i++) begin
            run_block(1'b0, 1'b1, 3, "R6 solo", c);
            check_val("R6 solo downlink", c, 1);
        end
        // R9: contention after an over-budget solo run goes to the other class
        ul_weight = 8'd4;
        run_block(1'b1, 1'b1, 2, "R9 switch", c);
        check_val("R9 switch after solo", c, 0);

        // R7: uplink stops mid-burst, downlink gets a fresh 3-block burst
        run_block(1'b0, 1'b1, 2, "R7 handover", c);
        check_val("R7 handover", c, 1);
        for (int i = 0; i < 3; i++) begin
            run_block(1'b1, 1'b1, 2, "R7 fresh burst", c);
            check_val("R7 fresh burst order", c, (i < 2) ? 1 : 0);
        end

        // R8: mixed block lengths, ul weight 1, dl weight 1; cur=UL used=1
        ul_weight = 8'd1;
        dl_weight = 8'd1;
        for (int i = 0; i < 6; i++) begin
            run_block(1'b1, 1'b1, (i % 2 == 0) ? 1 : 9, "R8 lengths", c);
            check_val("R8 length independent", c, (i < 2 || i == 5) ? 0 : (1));
        end

        // R10: class encoding during a block
        step(1'b0, 1'b1, 1'b0, "R10 accept dl");
        step(1'b0, 1'b0, 1'b0, "R10 dl busy");
        check_val("R10 busy_class downlink", int'(busy_class), 1);
        step(1'b0, 1'b0, 1'b1, "R10 done");
        step(1'b1, 1'b0, 1'b0, "R10 accept ul");
        step(1'b0, 1'b0, 1'b0, "R10 ul busy");
        check_val("R10 busy_class uplink", int'(busy_class), 0);
        step(1'b0, 1'b0, 1'b1, "R10 done ul");
        step(1'b0, 1'b0, 1'b0, "R3 free after done");
        check_val("R3 free after done", int'(busy), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule